// File: doc/BRIEF.md
# Agree-Mode Global-History Branch Predictor

This block predicts conditional branch directions from a table of two-bit saturating counters that is indexed only by a global history register. The counters do not hold a taken or not-taken guess. Each counter holds a guess of whether the branch will match the static bias bit that the branch carries. At prediction time the block reads one counter and combines it with the incoming bias bit to produce the direction. The direction equals the bias bit when agreement is predicted. It is the inverted bias bit when disagreement is predicted.

When a branch resolves, the front end returns the resolved outcome, the bias bit and an inversion hint, plus the history checkpoint that the block reported with the prediction. The counter selected by that checkpoint steps toward "agree" when the outcome matched the bias, and toward "disagree" when it did not. The global history shifts in the outcome XORed with the hint. This lets compiled code steer which paths share a counter without putting the hint on the lookup path.

The counter table carries no reset, so that it can map onto plain RAM. After reset the block therefore sweeps every entry to the weakly-agree state, and it accepts no work until the sweep is finished.

Top module: `agree_gpred`

## Requirements
- R1: After reset is released, `ready` is low and rises on the 2^HIST_W-th rising clock edge, which is 2048 edges with the default HIST_W = 11. Once high, it stays high until the next reset.
- R2: After the sweep, every counter is weakly agree (binary 10), and the global history is all zeros. A first prediction therefore reports `pred_agree` = 1, `pred_dir` equal to the bias bit, and `pred_ckpt` = 0.
- R3: A prediction request accepted on one clock edge produces `pred_vld` = 1 in the following cycle. In that cycle `pred_agree` is the MSB of the selected counter, and `pred_dir` = bias XOR (NOT `pred_agree`).
- R4: An update increments the counter at `upd_ckpt` when `upd_taken` equals `upd_bias` and decrements it otherwise. The counter saturates at 3 and at 0: it neither wraps nor moves past either end.
- R5: Each accepted update shifts the global history left by one bit, and `upd_taken` XOR `upd_hint` enters at bit 0. `pred_ckpt` reports the history value used to index the prediction.
- R6: An update changes only the counter addressed by `upd_ckpt`, whatever the current global history is.
- R7: While `ready` is low, prediction and update requests are ignored. No `pred_vld` is produced, and neither the history nor the counters change.
- R8: When a prediction and an update are accepted on the same edge, the prediction uses the counter and history values from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | output | 1 | High once the counter sweep has finished |
| pred_req | input | 1 | Prediction request |
| pred_bias | input | 1 | Static bias bit of the branch being predicted |
| pred_vld | output | 1 | A prediction result is valid this cycle |
| pred_dir | output | 1 | Predicted direction, 1 = taken |
| pred_agree | output | 1 | MSB of the selected counter, 1 = agreement predicted |
| pred_ckpt | output | HIST_W | History value that indexed this prediction |
| upd_req | input | 1 | Update request for a resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_bias | input | 1 | Bias bit of the resolved branch |
| upd_hint | input | 1 | Inversion hint of the resolved branch |
| upd_ckpt | input | HIST_W | Checkpoint returned with the prediction |

## Verification
A wrong counter step or a missing saturation shows only when that entry is predicted again. A disagreement is required before `pred_agree` falls, so a counter stuck at an end or wrapping reveals itself within two or three updates to one entry. A history that shifts the wrong bit, or shifts on the wrong edge, shows at `pred_ckpt` on the very next prediction. It then spreads to every following direction, because later lookups land on different entries. An incomplete sweep or a late `ready` shows as a miscounted rise edge, or as a first prediction that is not weakly agree.

// File: rtl/agree_gpred_pkg.sv
package agree_gpred_pkg;

  localparam int CTR_W = 2;

  typedef logic [CTR_W-1:0] ctr_t;

  localparam ctr_t CTR_MAX  = ctr_t'((1 << CTR_W) - 1);
  localparam ctr_t CTR_MIN  = ctr_t'(0);
  localparam ctr_t CTR_WEAK = ctr_t'(1 << (CTR_W - 1));

  // saturating step: toward agree when the branch matched its bias
  function automatic ctr_t ctr_step(input ctr_t cur, input logic agreed);
    ctr_t res;
    if (agreed) res = (cur == CTR_MAX) ? cur : cur + ctr_t'(1);
    else        res = (cur == CTR_MIN) ? cur : cur - ctr_t'(1);
    return res;
  endfunction

endpackage

// File: rtl/agree_ghr.sv
module agree_ghr #(
  parameter int HIST_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);

  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], shift_bit};
  end

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (hist[0] == $past(shift_bit)) &&
                 (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0]))); // R5

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist)); // R7

endmodule

// File: rtl/agree_pht.sv
module agree_pht
  import agree_gpred_pkg::*;
#(
  parameter int HIST_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  output logic              ready,
  input  logic              rd_en,
  input  logic [HIST_W-1:0] rd_idx,
  output ctr_t              rd_ctr,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_agreed
);

  localparam int DEPTH = 1 << HIST_W;
  localparam logic [HIST_W-1:0] LAST_IDX = HIST_W'(DEPTH - 1);

  ctr_t              table_q [DEPTH];
  logic              sweeping;
  logic [HIST_W-1:0] sweep_idx;
  ctr_t              old_ctr;
  ctr_t              new_ctr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sweeping  <= 1'b1;
      sweep_idx <= '0;
    end else if (sweeping) begin
      sweep_idx <= sweep_idx + 1'b1;
      if (sweep_idx == LAST_IDX) sweeping <= 1'b0;
    end
  end

  assign ready   = !sweeping;
  assign old_ctr = table_q[wr_idx];
  assign new_ctr = ctr_step(old_ctr, wr_agreed);

  // single write port, no reset on the array
  always_ff @(posedge clk) begin
    if (sweeping)   table_q[sweep_idx] <= CTR_WEAK;
    else if (wr_en) table_q[wr_idx]    <= new_ctr;
  end

  // registered read; same-edge write is not visible
  always_ff @(posedge clk) begin
    if (rd_en) rd_ctr <= table_q[rd_idx];
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R1

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sweeping) |->
      !((old_ctr == CTR_MAX && new_ctr == CTR_MIN) ||
        (old_ctr == CTR_MIN && new_ctr == CTR_MAX))); // R4

endmodule

// File: rtl/agree_gpred.sv
module agree_gpred
  import agree_gpred_pkg::*;
#(
  parameter int HIST_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  output logic              ready,
  input  logic              pred_req,
  input  logic              pred_bias,
  output logic              pred_vld,
  output logic              pred_dir,
  output logic              pred_agree,
  output logic [HIST_W-1:0] pred_ckpt,
  input  logic              upd_req,
  input  logic              upd_taken,
  input  logic              upd_bias,
  input  logic              upd_hint,
  input  logic [HIST_W-1:0] upd_ckpt
);

  logic              pred_fire;
  logic              upd_fire;
  logic [HIST_W-1:0] hist;
  ctr_t              sel_ctr;
  logic              bias_q;

  assign pred_fire = pred_req && ready;
  assign upd_fire  = upd_req && ready;

  agree_ghr #(.HIST_W(HIST_W)) i_ghr (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (upd_fire),
    .shift_bit (upd_taken ^ upd_hint),
    .hist      (hist)
  );

  agree_pht #(.HIST_W(HIST_W)) i_pht (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .rd_en     (pred_fire),
    .rd_idx    (hist),
    .rd_ctr    (sel_ctr),
    .wr_en     (upd_fire),
    .wr_idx    (upd_ckpt),
    .wr_agreed (upd_taken == upd_bias)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_vld  <= 1'b0;
      bias_q    <= 1'b0;
      pred_ckpt <= '0;
    end else begin
      pred_vld <= pred_fire;
      if (pred_fire) begin
        bias_q    <= pred_bias;
        pred_ckpt <= hist;
      end
    end
  end

  assign pred_agree = sel_ctr[CTR_W-1];
  assign pred_dir   = bias_q ^ ~pred_agree;

  AST_VLD_TIMING: assert property (@(posedge clk) disable iff (rst)
    pred_vld == $past(pred_req && ready)); // R3

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !pred_vld); // R7

  AST_CKPT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    pred_vld |-> pred_ckpt == $past(hist)); // R5

endmodule

// File: tb/test_agree_gpred.sv
module test_agree_gpred;

  localparam int HW    = 11;
  localparam int DEPTH = 1 << HW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ready;
  logic          pred_req = 1'b0, pred_bias = 1'b0;
  logic          pred_vld, pred_dir, pred_agree;
  logic [HW-1:0] pred_ckpt;
  logic          upd_req = 1'b0, upd_taken = 1'b0, upd_bias = 1'b0, upd_hint = 1'b0;
  logic [HW-1:0] upd_ckpt = '0;

  always #2.5 clk = ~clk;

  agree_gpred #(.HIST_W(HW)) i_agree_gpred (
    .clk(clk), .rst(rst), .ready(ready),
    .pred_req(pred_req), .pred_bias(pred_bias),
    .pred_vld(pred_vld), .pred_dir(pred_dir), .pred_agree(pred_agree),
    .pred_ckpt(pred_ckpt),
    .upd_req(upd_req), .upd_taken(upd_taken), .upd_bias(upd_bias),
    .upd_hint(upd_hint), .upd_ckpt(upd_ckpt)
  );

  typedef struct {
    logic    dir;
    logic    agree;
    int      ckpt;
    string   tag;
  } exp_t;

  exp_t exp_q[$];
  int   mdl_ctr [DEPTH];
  int   mdl_hist = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  task automatic fail_msg(string tag, string what, int act, int exp);
    n_bad++;
    $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
  endtask

  // driver: one cycle of stimulus, model updated in the same step
  task automatic step(input bit pv, input bit pb, input bit uv, input bit ut,
                      input bit ub, input bit uh, input int uc, input string tag);
    exp_t e;
    pred_req = pv; pred_bias = pb;
    upd_req = uv; upd_taken = ut; upd_bias = ub; upd_hint = uh;
    upd_ckpt = HW'(uc);
    if (pv) begin
      e.agree = (mdl_ctr[mdl_hist] >= 2);
      e.dir   = pb ^ ~e.agree;
      e.ckpt  = mdl_hist;
      e.tag   = tag;
      exp_q.push_back(e);  // R8: sampled before this cycle's update
    end
    if (uv) begin
      if (ut == ub) begin if (mdl_ctr[uc] < 3) mdl_ctr[uc]++; end
      else          begin if (mdl_ctr[uc] > 0) mdl_ctr[uc]--; end
      mdl_hist = ((mdl_hist << 1) | int'(ut ^ uh)) & (DEPTH - 1);
    end
    @(negedge clk);
    pred_req = 1'b0; upd_req = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (pred_vld) begin
        n_chk++;
        if (exp_q.size() == 0) fail_msg("R7", "unexpected pred_vld", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          if (pred_dir !== e.dir)     fail_msg(e.tag, "pred_dir", pred_dir, e.dir);
          if (pred_agree !== e.agree) fail_msg(e.tag, "pred_agree", pred_agree, e.agree);
          if (int'(pred_ckpt) != e.ckpt) fail_msg(e.tag, "pred_ckpt", int'(pred_ckpt), e.ckpt);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    for (int i = 0; i < DEPTH; i++) mdl_ctr[i] = 2;
    repeat (3) @(negedge clk);
    n_chk++;
    if (ready !== 1'b0 || pred_vld !== 1'b0)
      fail_msg("R1", "reset state ready/vld", int'(ready), 0);
    rst = 1'b0;
    cnt = 0;
    while (!ready) begin
      // R7: requests during the sweep must leave no trace
      if (cnt == 10) begin
        pred_req = 1'b1; upd_req = 1'b1; upd_taken = 1'b1; upd_hint = 1'b0;
        upd_bias = 1'b0; upd_ckpt = '0;
      end else begin
        pred_req = 1'b0; upd_req = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    pred_req = 1'b0; upd_req = 1'b0;
    n_chk++;
    if (cnt != DEPTH) fail_msg("R1", "sweep length", cnt, DEPTH);

    // R2: first predictions, weakly agree, history zero
    step(1, 1, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, 0, "R2");
    // R3/R4: two disagreements on entry 0 flip to disagree (hint keeps history 0)
    step(0, 0, 1, 1, 0, 1, 0, "R4");
    step(1, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 1, 0, 1, 0, "R4");
    step(1, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 1, 0, 0, 0, 0, 0, "R3");
    // R4: saturate low, one agree must not flip
    step(0, 0, 1, 0, 1, 0, 0, "R4");
    step(0, 0, 1, 0, 1, 0, 0, "R4");
    step(0, 0, 1, 1, 1, 1, 0, "R4");
    step(1, 1, 0, 0, 0, 0, 0, "R4");
    // R4: saturate high, one disagree keeps agree
    for (int i = 0; i < 5; i++) step(0, 0, 1, 1, 1, 1, 0, "R4");
    step(0, 0, 1, 0, 1, 0, 0, "R4");
    step(1, 0, 0, 0, 0, 0, 0, "R4");
    // R6: update a non-current entry; entry 0 unchanged
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, 1, 5, "R6");
    step(1, 1, 0, 0, 0, 0, 0, "R6");
    // R5: shift a pattern via taken XOR hint, then probe
    step(0, 0, 1, 1, 1, 0, 9, "R5");
    step(0, 0, 1, 0, 0, 1, 9, "R5");
    step(0, 0, 1, 1, 1, 1, 9, "R5");
    step(1, 0, 0, 0, 0, 0, 0, "R5");
    // R8: same-edge prediction and update on the current entry
    step(1, 1, 1, 0, 1, 0, mdl_hist, "R8");
    step(1, 1, 1, 0, 1, 0, mdl_hist, "R8");
    step(1, 1, 0, 0, 0, 0, 0, "R8");
    // mixed stream
    for (int i = 0; i < 4000; i++) begin
      int uc;
      uc = ($urandom_range(0, 1) == 1) ? mdl_hist : int'($urandom_range(0, 15));
      step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           $urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, uc, "R5");
    end
    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) fail_msg("R3", "missing predictions", 0, exp_q.size());
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule